// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Bank

This block places three independent 16-bit down-counting timers behind one 32-bit word-wide register port. Address bits [7:6] pick the channel and bits [5:0] pick the register inside it. Each channel holds the following registers:

- a control word whose bit 1 starts and stops counting;
- a mode word, stored only;
- the live counter;
- three 32-bit compare words;
- a status word;
- an interrupt mask, set and cleared through two write-only strobes.

Software loads the counter by writing it directly, or by writing the third compare word. Both writes also set the value that is restored each time the counter passes through zero.

Each channel drives its own interrupt line, high whenever a status bit that is also unmasked is set. Read data is returned combinationally in the cycle the read strobe is high. A read's side effect on the status word takes place at the following clock edge. There is no handshake: every access completes in one cycle.

Top module: `tmr_bank`

## Requirements
- R1: The channel index is `bus_addr[7:6]`, with channels 0 to 2 populated. The register is selected by `bus_addr[5:0]`:
  - 0x00 control
  - 0x04 mode
  - 0x10 counter
  - 0x14 compare A
  - 0x18 compare B
  - 0x1C compare C
  - 0x20 status
  - 0x24 mask-set
  - 0x28 mask-clear
  - 0x2C mask

  An access to one channel leaves the other channels unchanged.
- R2: After reset every register and counter is zero, every channel is stopped, and every `irq` bit is 0.
- R3: A control write stores the full word. If bit 1 of the written data is 1 the channel stops counting; if it is 0 the channel counts from the next cycle on.
- R4: A write to the counter (0x10) or to compare C (0x1C) loads both the live counter and the reload value with data bits [15:0]. This load has priority over counting in the same cycle. A counter read returns the live count, zero-extended.
- R5: While running, the counter drops by one each cycle. In the cycle after it holds zero it takes the reload value and status bit 4 becomes 1. While stopped, the counter holds its value.
- R6: A status read returns the current word, and status bit 4 is clear after that cycle's edge. If a reload happens in the same cycle, bit 4 stays 1.
- R7: A status write replaces the whole status word with the written data.
- R8: A mask-set write ORs its data into the mask, and a mask-clear write clears the written bits. Reading 0x2C returns the mask. Reads of 0x24 and 0x28 return zero.
- R9: `irq[n]` is 1 exactly when channel n's status AND mask is nonzero.
- R10: An access to an unlisted offset, or to channel index 3, reads as zero. A write there changes no register in any channel.
- R11: The mode, compare A, compare B and compare C words keep all 32 written bits and read them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_addr | input | 8 | [7:6] channel, [5:0] register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 3 | Per-channel interrupt, bit n for channel n |

## Verification
The bench builds the bank with its defaults: three channels, 16-bit counters and an 8-bit address. This leaves channel index 3 addressable but unpopulated, so the undecoded-channel path is reachable from the bus. Small reload values of 1, 5 and 7 bring a counter to zero within a few cycles. That lets the bench land a status read exactly on the reload cycle and confirm that the new flag survives the read.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

  typedef enum logic [3:0] {
    REG_CTRL,
    REG_MODE,
    REG_COUNT,
    REG_CMPA,
    REG_CMPB,
    REG_CMPC,
    REG_STAT,
    REG_MSET,
    REG_MCLR,
    REG_MASK,
    REG_NONE
  } reg_id_e;

  localparam int CTRL_STOP_BIT = 1;
  localparam int STAT_WRAP_BIT = 4;

  function automatic reg_id_e map_offset(input logic [5:0] off);
    case (off)
      6'h00:   map_offset = REG_CTRL;
      6'h04:   map_offset = REG_MODE;
      6'h10:   map_offset = REG_COUNT;
      6'h14:   map_offset = REG_CMPA;
      6'h18:   map_offset = REG_CMPB;
      6'h1C:   map_offset = REG_CMPC;
      6'h20:   map_offset = REG_STAT;
      6'h24:   map_offset = REG_MSET;
      6'h28:   map_offset = REG_MCLR;
      6'h2C:   map_offset = REG_MASK;
      default: map_offset = REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tmr_bank_decode.sv
module tmr_bank_decode
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] ch_sel,
  output reg_id_e           reg_id,
  output logic              hit
);
  localparam int CH_W = ADDR_W - OFF_W;

  logic [CH_W-1:0] ch_idx;

  assign ch_idx = addr[ADDR_W-1:OFF_W];
  assign reg_id = map_offset(addr[OFF_W-1:0]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign ch_sel[g] = (ch_idx == CH_W'(g)) && (reg_id != REG_NONE);
  end

  assign hit = |ch_sel;

endmodule

// File: rtl/tmr_bank_counter.sv
module tmr_bank_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] value,
  output logic             wrap
);
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;

  assign value = cnt_q;
  assign wrap  = run && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load) begin
      cnt_q    <= load_val;
      reload_q <= load_val;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n) load |=> value == $past(load_val)); // R4
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (run && !load && value != '0) |=> value == $past(value) - 1'b1); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (!run && !load) |=> $stable(value)); // R5

endmodule

// File: rtl/tmr_bank_channel.sv
module tmr_bank_channel
  import tmr_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  reg_id_e           reg_id,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] ctrl_q, mode_q, cmpa_q, cmpb_q, cmpc_q;
  logic [DATA_W-1:0] stat_q, stat_n, mask_q, mask_n;
  logic              run_q;
  logic              we, re;
  logic              cnt_load, cnt_wrap;
  logic [CNT_W-1:0]  cnt_val;

  assign we = sel && wr;
  assign re = sel && rd;
  assign cnt_load = we && (reg_id == REG_COUNT || reg_id == REG_CMPC);

  tmr_bank_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .load     (cnt_load),
    .load_val (wdata[CNT_W-1:0]),
    .value    (cnt_val),
    .wrap     (cnt_wrap)
  );

  always_comb begin
    stat_n = stat_q;
    if (we && reg_id == REG_STAT)      stat_n = wdata;
    else if (re && reg_id == REG_STAT) stat_n[STAT_WRAP_BIT] = 1'b0;
    if (cnt_wrap)                      stat_n[STAT_WRAP_BIT] = 1'b1;
  end

  always_comb begin
    mask_n = mask_q;
    if (we && reg_id == REG_MSET) mask_n = mask_q | wdata;
    if (we && reg_id == REG_MCLR) mask_n = mask_q & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      cmpc_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
      run_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
      if (we) begin
        case (reg_id)
          REG_CTRL: begin
            ctrl_q <= wdata;
            run_q  <= !wdata[CTRL_STOP_BIT];
          end
          REG_MODE: mode_q <= wdata;
          REG_CMPA: cmpa_q <= wdata;
          REG_CMPB: cmpb_q <= wdata;
          REG_CMPC: cmpc_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_id)
      REG_CTRL:  rdata = ctrl_q;
      REG_MODE:  rdata = mode_q;
      REG_COUNT: rdata = {{PAD_W{1'b0}}, cnt_val};
      REG_CMPA:  rdata = cmpa_q;
      REG_CMPB:  rdata = cmpb_q;
      REG_CMPC:  rdata = cmpc_q;
      REG_STAT:  rdata = stat_q;
      REG_MASK:  rdata = mask_q;
      default:   rdata = '0;
    endcase
  end

  assign irq = |(stat_q & mask_q);

  AST_RUN_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n) (we && reg_id == REG_CTRL) |=> run_q == !$past(wdata[CTRL_STOP_BIT])); // R3
  AST_STAT_RDCLR: assert property (@(posedge clk) disable iff (!rst_n) (re && !we && reg_id == REG_STAT && !cnt_wrap) |=> !stat_q[STAT_WRAP_BIT]); // R6
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cnt_wrap |=> stat_q[STAT_WRAP_BIT]); // R5
  AST_MSET_ORS: assert property (@(posedge clk) disable iff (!rst_n) (we && reg_id == REG_MSET) |=> ((mask_q & $past(wdata)) == $past(wdata))); // R8
  AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (we && reg_id == REG_MCLR) |=> ((mask_q & $past(wdata)) == '0)); // R8

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int OFF_W = 6;

  logic [NUM_CH-1:0] ch_sel;
  reg_id_e           reg_id;
  logic              hit;
  logic [DATA_W-1:0] ch_rdata [NUM_CH];

  tmr_bank_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .addr   (bus_addr),
    .ch_sel (ch_sel),
    .reg_id (reg_id),
    .hit    (hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_bank_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (ch_sel[g]),
      .wr    (bus_wr),
      .rd    (bus_rd),
      .reg_id(reg_id),
      .wdata (bus_wdata),
      .rdata (ch_rdata[g]),
      .irq   (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) bus_rdata = bus_rdata | ch_rdata[i];
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_sel)); // R1
  AST_UNDEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && !hit) |-> bus_rdata == '0); // R10

endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tmr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h44, 32'hA5A50001, 32'h0,        4'd11}, // R11 ch1 mode
    '{1'b0, 8'h44, 32'h0,        32'hA5A50001, 4'd11},
    '{1'b1, 8'h94, 32'h12345678, 32'h0,        4'd11}, // ch2 compare A
    '{1'b1, 8'h98, 32'hCAFE0000, 32'h0,        4'd11}, // ch2 compare B
    '{1'b0, 8'h94, 32'h0,        32'h12345678, 4'd11},
    '{1'b0, 8'h98, 32'h0,        32'hCAFE0000, 4'd11},
    '{1'b1, 8'h40, 32'h00000006, 32'h0,        4'd3},  // R3 ch1 control, stopped
    '{1'b0, 8'h40, 32'h0,        32'h00000006, 4'd3},
    '{1'b1, 8'h64, 32'h0000000F, 32'h0,        4'd8},  // R8 mask-set
    '{1'b1, 8'h68, 32'h00000005, 32'h0,        4'd8},  // mask-clear
    '{1'b0, 8'h6C, 32'h0,        32'h0000000A, 4'd8},
    '{1'b0, 8'h64, 32'h0,        32'h00000000, 4'd8},
    '{1'b1, 8'h9C, 32'hABCD0007, 32'h0,        4'd4},  // R4 ch2 compare C
    '{1'b0, 8'h9C, 32'h0,        32'hABCD0007, 4'd11},
    '{1'b0, 8'h90, 32'h0,        32'h00000007, 4'd4},
    '{1'b0, 8'h04, 32'h0,        32'h00000000, 4'd1}   // R1 ch0 untouched
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk("R2 irq", {29'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R2 ctrl", v, 32'h0);
    idle(3);
    rd(8'h10, v); chk("R2 counter held", v, 32'h0);
    rd(8'h20, v); chk("R2 status", v, 32'h0);
    rd(8'h2C, v); chk("R2 mask", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, v);
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
      end
    end
    chk("R9 no irq ch1 status zero", {29'b0, irq}, 32'h0);

    // R5 counting on ch0
    wr(8'h10, 32'hFFFF0005);
    wr(8'h00, 32'h0);
    idle(2);
    wr(8'h00, 32'h2);
    rd(8'h10, v); chk("R5 three decrements", v, 32'h2);
    idle(2);
    rd(8'h10, v); chk("R5 held while stopped", v, 32'h2);
    rd(8'h20, v); chk("R5 no flag yet", v, 32'h0);
    wr(8'h00, 32'h0);
    idle(2);
    wr(8'h00, 32'h2);
    rd(8'h10, v); chk("R5 reload after zero", v, 32'h5);
    wr(8'h24, 32'h10);
    chk("R9 irq on flag", {29'b0, irq}, 32'h1);
    rd(8'h20, v); chk("R5 flag set", v, 32'h10);
    chk("R6 irq after read clear", {29'b0, irq}, 32'h0);
    rd(8'h20, v); chk("R6 flag cleared", v, 32'h0);
    wr(8'h28, 32'h10);

    // R4 load wins over counting
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h00001234);
    wr(8'h00, 32'h2);
    rd(8'h10, v); chk("R4 load then one decrement", v, 32'h1233);
    wr(8'h1C, 32'h00000003);
    rd(8'h10, v); chk("R4 compare C loads counter", v, 32'h3);

    // R6 reload in same cycle as status read keeps flag
    wr(8'h20, 32'h0);
    wr(8'h10, 32'h1);
    wr(8'h00, 32'h0);
    idle(1);
    rd(8'h20, v); chk("R6 read during reload", v, 32'h0);
    wr(8'h00, 32'h2);
    rd(8'h20, v); chk("R6 flag survives read", v, 32'h10);
    rd(8'h20, v); chk("R6 cleared by later read", v, 32'h0);
    rd(8'h10, v); chk("R5 counter after reload step", v, 32'h0);

    // R7 status write and R9 irq
    wr(8'h20, 32'h3);
    wr(8'h24, 32'h1);
    chk("R9 irq from written status", {29'b0, irq}, 32'h1);
    rd(8'h20, v); chk("R7 status replaced", v, 32'h3);
    wr(8'h28, 32'h1);
    chk("R9 irq masked", {29'b0, irq}, 32'h0);

    // R10 undecoded accesses
    wr(8'h08, 32'hFFFFFFFF);
    wr(8'hC4, 32'hFFFFFFFF);
    wr(8'hE4, 32'hFFFFFFFF);
    rd(8'h08, v); chk("R10 undecoded offset", v, 32'h0);
    rd(8'hC4, v); chk("R10 channel 3", v, 32'h0);
    rd(8'h04, v); chk("R10 ch0 mode untouched", v, 32'h0);
    rd(8'h2C, v); chk("R10 ch0 mask untouched", v, 32'h0);
    rd(8'hAC, v); chk("R10 ch2 mask untouched", v, 32'h0);
    chk("R10 irq unchanged", {29'b0, irq}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule